// File: doc/BRIEF.md
# SMBus Target Engine with Packet Error Code

This block is the bus end of a power-management target on a two-wire SMBus/PMBus link. It synchronises and samples SCL and SDA. It recognises START, repeated START and STOP, and compares the first byte after a START with its own 7-bit address. Write bytes go to the register side as single-cycle strobes. Read bytes come from the register side through a request/acknowledge pair, and SCL is held low while the engine waits for them.

A running CRC-8 covers every byte of a transaction. That includes each address byte with its R/W bit, and it carries across a repeated START. The register side states how many bytes a write should contain. A write with exactly that many bytes is accepted as it is. A write with one byte more is treated as carrying a trailing check byte, and that byte must verify. A write with any other length is dropped. Every read response ends with the check byte the engine computes itself.

The own address is built from two strap readings, each one a 4-bit code that carries an octal digit. Fixed SMBus addresses are flagged on a status output. The low period of SCL that the engine causes is bounded by a timer. The timer is derived from the system clock frequency and a limit given in microseconds.

Top module: `smb_target`

## Requirements
- R1: With both strap codes below 8, `own_addr` equals 8*`strap_hi` + `strap_lo`, giving a value from 0 to 63.
- R2: If either strap code is 8 or above, `own_addr` is 127. The engine then answers at 127 and no longer at the strap-built address.
- R3: `addr_reserved` is 1 only for a strap-built address of 0 to 12, 40, 44, 45 or 55. It is 0 for every other address, including the fallback address 127.
- R4: After a START, the engine acknowledges the address byte (pulls SDA low in the ninth clock) only when bits 7:1 equal `own_addr`. A mismatch gets no acknowledge and produces no register traffic.
- R5: In a write, every data byte is acknowledged. The first `wr_len` bytes are presented in order on `wr_data` with a one-cycle `wr_valid`. At STOP or repeated START, a count equal to `wr_len` gives one `wr_commit` pulse.
- R6: A write of `wr_len`+1 bytes whose last byte is the CRC-8 (polynomial 0x07, initial value 0x00, MSB first) of all earlier bytes, address included, gives `wr_commit`. The check byte is never presented on `wr_data`.
- R7: A write of `wr_len`+1 bytes with a wrong check byte gives `wr_abort` and sets `pec_err`. `pec_err` stays set through later transactions until `pec_err_clr` is pulsed.
- R8: A write whose byte count is neither `wr_len` nor `wr_len`+1 gives `wr_abort` and leaves `pec_err` unchanged.
- R9: When a read byte is due, `rd_req` rises and SCL is held low (`scl_oe`=1) until `rd_ack`. `rd_data` is then shifted out MSB first.
- R10: After the data byte that came with `rd_last`=1, the next byte sent is the CRC-8 over the whole transaction: the write address, the command, the read address and all data bytes. A repeated START does not restart the CRC, and the write phase before it is committed under the R5 rule.
- R11: Any read byte requested after the check byte is 0xFF.
- R12: No single SCL low period driven by the engine is longer than LIMIT = CLK_HZ/1e6 * STRETCH_US cycles. When that limit is reached, SCL and SDA are released, the request is withdrawn and the host reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_hi | input | 4 | High octal digit code; 8 and above is invalid |
| strap_lo | input | 4 | Low octal digit code; 8 and above is invalid |
| own_addr | output | 7 | Address the engine answers at |
| addr_reserved | output | 1 | Strap address is a fixed SMBus address |
| wr_len | input | 8 | Expected write byte count, check byte excluded |
| wr_valid | output | 1 | One-cycle strobe for a write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | Write phase accepted |
| wr_abort | output | 1 | Write phase dropped |
| rd_req | output | 1 | Read byte wanted |
| rd_ack | input | 1 | Read byte supplied on rd_data |
| rd_data | input | 8 | Read byte |
| rd_last | input | 1 | This read byte is the last data byte |
| pec_err | output | 1 | Sticky check-byte mismatch |
| pec_err_clr | input | 1 | Clears pec_err |

## Verification
The hardest case to reach is the stretch limit. The register side must stay silent for longer than the timer while the host is waiting on a held SCL. The bench uses a short limit and a register-side responder whose delay can be set. One read runs with a delay well under the limit and another with a delay over it. In both, the bench measures the longest low run of `scl_oe` at the port. The check-byte path on reads is reached with full command/repeated-START/read sequences of several lengths. The bench computes the expected CRC itself from the bytes it puts on the bus.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam int CNT_W = 8;
  localparam logic [6:0] FALLBACK_ADDR = 7'h7F;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ACK_A, S_WDATA, S_ACK_W, S_FETCH, S_RDATA, S_RACK
  } bus_state_t;

  typedef enum logic [1:0] {EW_NONE, EW_COMMIT, EW_ABORT, EW_PECBAD} wr_end_t;

  // CRC-8, x^8+x^2+x+1, one data bit per step, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [6:0] strap_addr(input logic [3:0] hi, input logic [3:0] lo);
    if (hi[3] || lo[3]) return FALLBACK_ADDR;
    return {1'b0, hi[2:0], lo[2:0]};
  endfunction

  function automatic logic addr_fixed(input logic [6:0] a);
    return (a <= 7'd12) || (a == 7'd40) || (a == 7'd44) || (a == 7'd45) || (a == 7'd55);
  endfunction

  function automatic wr_end_t wr_end(input logic [CNT_W-1:0] n, input logic [CNT_W-1:0] e,
                                     input logic crc_zero);
    if (n == '0) return EW_NONE;
    if (n == e) return EW_COMMIT;
    if ({1'b0, n} == {1'b0, e} + 1'b1) return crc_zero ? EW_COMMIT : EW_PECBAD;
    return EW_ABORT;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  // R4: a bus condition is only seen while SCL is steady high
  a_r4_cond_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |-> $stable(scl_s));
endmodule

// File: rtl/smb_addr_form.sv
module smb_addr_form (
  input  logic [3:0] strap_hi,
  input  logic [3:0] strap_lo,
  output logic [6:0] own_addr,
  output logic       addr_reserved
);
  import smb_pkg::*;

  assign own_addr      = strap_addr(strap_hi, strap_lo);
  assign addr_reserved = (own_addr != FALLBACK_ADDR) && addr_fixed(own_addr);

  always_comb begin
    // R1/R2: either a 6-bit strap address or the fallback
    a_r2_range: assert (own_addr[6] == 1'b0 || own_addr == FALLBACK_ADDR);
    // R3: fallback is never flagged
    a_r3_flag: assert (!(addr_reserved && own_addr[6]));
  end
endmodule

// File: rtl/smb_stretch_timer.sv
module smb_stretch_timer #(
  parameter int LIMIT = 7000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!hold)    cnt <= '0;
    else if (!expired) cnt <= cnt + CW'(1);
  end

  assign expired = (cnt == LIM);

  // R12: dropping the hold rearms the timer
  a_r12_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |=> !expired);
endmodule

// File: rtl/smb_target.sv
module smb_target #(
  parameter int CLK_HZ     = 200000000,
  parameter int STRETCH_US = 35000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [3:0] strap_hi,
  input  logic [3:0] strap_lo,
  output logic [6:0] own_addr,
  output logic       addr_reserved,
  input  logic [7:0] wr_len,
  output logic       wr_valid,
  output logic [7:0] wr_data,
  output logic       wr_commit,
  output logic       wr_abort,
  output logic       rd_req,
  input  logic       rd_ack,
  input  logic [7:0] rd_data,
  input  logic       rd_last,
  output logic       pec_err,
  input  logic       pec_err_clr
);
  import smb_pkg::*;

  localparam int LIMIT = (CLK_HZ / 1000000) * STRETCH_US;
  localparam int RW    = $clog2(LIMIT + 2);

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic expired, hold;

  bus_state_t       state;
  logic [7:0]       shreg, crc;
  logic [3:0]       bitcnt;
  logic [CNT_W-1:0] wcount;
  logic             rw, busy, mack, pec_next, pec_sent;

  wr_end_t    end_kind;
  logic       load_en;
  logic [7:0] load_val;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  smb_addr_form u_addr (
    .strap_hi(strap_hi), .strap_lo(strap_lo),
    .own_addr(own_addr), .addr_reserved(addr_reserved)
  );

  smb_stretch_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold(hold), .expired(expired)
  );

  assign hold     = (state == S_FETCH);
  assign scl_oe   = hold && !expired;
  assign rd_req   = hold && !pec_next && !pec_sent && !expired;
  assign end_kind = wr_end(wcount, wr_len, crc == 8'h00);

  always_comb begin
    load_en  = 1'b0;
    load_val = 8'hFF;
    if (pec_next)    begin load_en = 1'b1; load_val = crc;     end
    else if (pec_sent) begin load_en = 1'b1; load_val = 8'hFF; end
    else if (rd_ack) begin load_en = 1'b1; load_val = rd_data; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; shreg <= '0; crc <= '0; bitcnt <= '0; wcount <= '0;
      rw <= 1'b0; busy <= 1'b0; mack <= 1'b0; pec_next <= 1'b0; pec_sent <= 1'b0;
      sda_oe <= 1'b0; wr_valid <= 1'b0; wr_data <= '0; wr_commit <= 1'b0;
      wr_abort <= 1'b0; pec_err <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      wr_abort  <= 1'b0;
      if (pec_err_clr) pec_err <= 1'b0;

      if (start_c || stop_c) begin
        case (end_kind)
          EW_COMMIT: wr_commit <= 1'b1;
          EW_ABORT:  wr_abort  <= 1'b1;
          EW_PECBAD: begin wr_abort <= 1'b1; pec_err <= 1'b1; end
          default: ;
        endcase
        wcount <= '0; sda_oe <= 1'b0; bitcnt <= '0;
        pec_next <= 1'b0; pec_sent <= 1'b0;
        if (stop_c) begin
          state <= S_IDLE; busy <= 1'b0; crc <= '0;
        end else begin
          state <= S_ADDR; busy <= 1'b1;
          if (!busy) crc <= '0;
        end
      end else begin
        case (state)
          S_ADDR: begin
            if (scl_rise) begin shreg <= {shreg[6:0], sda_s}; bitcnt <= bitcnt + 4'd1; end
            if (scl_fall && bitcnt == 4'd8) begin
              if (shreg[7:1] == own_addr) begin
                crc <= crc8_step(crc, shreg); rw <= shreg[0];
                sda_oe <= 1'b1; state <= S_ACK_A;
              end else state <= S_IDLE;
            end
          end
          S_ACK_A: if (scl_fall) begin
            sda_oe <= 1'b0; bitcnt <= '0;
            state <= rw ? S_FETCH : S_WDATA;
          end
          S_WDATA: begin
            if (scl_rise) begin shreg <= {shreg[6:0], sda_s}; bitcnt <= bitcnt + 4'd1; end
            if (scl_fall && bitcnt == 4'd8) begin
              crc <= crc8_step(crc, shreg);
              if (wcount < wr_len) begin wr_valid <= 1'b1; wr_data <= shreg; end
              if (wcount != '1) wcount <= wcount + 1'b1;
              sda_oe <= 1'b1; state <= S_ACK_W;
            end
          end
          S_ACK_W: if (scl_fall) begin sda_oe <= 1'b0; bitcnt <= '0; state <= S_WDATA; end
          S_FETCH: begin
            if (load_en) begin
              shreg <= load_val; sda_oe <= ~load_val[7]; bitcnt <= '0; state <= S_RDATA;
              if (pec_next) begin pec_next <= 1'b0; pec_sent <= 1'b1; end
              else if (!pec_sent) begin crc <= crc8_step(crc, rd_data); pec_next <= rd_last; end
            end else if (expired) state <= S_IDLE;
          end
          S_RDATA: begin
            if (scl_rise) bitcnt <= bitcnt + 4'd1;
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin sda_oe <= 1'b0; state <= S_RACK; end
              else begin shreg <= {shreg[6:0], 1'b0}; sda_oe <= ~shreg[6]; end
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) state <= mack ? S_FETCH : S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // independent run-length of the stretch, for R12
  logic [RW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_run <= '0;
    else if (scl_oe) low_run <= low_run + RW'(1);
    else             low_run <= '0;
  end

  a_r12_stretch_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (low_run < RW'(LIMIT)));
  a_r9_req_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> scl_oe);
  a_r7_pec_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pec_err && !pec_err_clr) |=> pec_err);
  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_commit && wr_abort));
  a_r4_drive_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

// File: tb/test_smb_target.sv
module test_smb_target;
  localparam int H = 20;
  localparam int LIMIT = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic [3:0] strap_hi = 4'd3, strap_lo = 4'd2;
  logic [6:0] own_addr;
  logic addr_reserved;
  logic [7:0] wr_len = 8'd2;
  logic wr_valid, wr_commit, wr_abort, rd_req, pec_err;
  logic [7:0] wr_data;
  logic rd_ack = 1'b0, rd_last = 1'b0, pec_err_clr = 1'b0;
  logic [7:0] rd_data = 8'h00;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  smb_target #(.CLK_HZ(200000000), .STRETCH_US(2)) i_smb_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .strap_hi(strap_hi), .strap_lo(strap_lo),
    .own_addr(own_addr), .addr_reserved(addr_reserved), .wr_len(wr_len),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_commit(wr_commit), .wr_abort(wr_abort),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data), .rd_last(rd_last),
    .pec_err(pec_err), .pec_err_clr(pec_err_clr)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_crc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x = c ^ b;
    for (int k = 0; k < 8; k++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  // monitor and register-side responder
  logic mon_clr = 1'b0;
  int rsp_delay = 60, rsp_n = 1;
  logic [7:0] rsp_mem [0:15];
  logic [7:0] wcap [0:15];
  int nwr = 0, ncommit = 0, nabort = 0, cur_run = 0, max_run = 0;

  initial forever begin
    @(negedge clk);
    if (mon_clr) begin nwr = 0; ncommit = 0; nabort = 0; cur_run = 0; max_run = 0; end
    else begin
      if (wr_valid) begin if (nwr < 16) wcap[nwr] = wr_data; nwr++; end
      if (wr_commit) ncommit++;
      if (wr_abort) nabort++;
      if (scl_oe) begin cur_run++; if (cur_run > max_run) max_run = cur_run; end
      else cur_run = 0;
    end
  end

  initial begin
    int wait_cnt = 0, idx = 0;
    forever begin
      @(negedge clk);
      if (mon_clr) idx = 0;
      if (rd_ack) begin rd_ack = 1'b0; wait_cnt = 0; end
      else if (rd_req) begin
        wait_cnt++;
        if (wait_cnt >= rsp_delay) begin
          rd_data = rsp_mem[idx % 16]; rd_last = (idx == rsp_n - 1); idx++; rd_ack = 1'b1;
        end
      end else wait_cnt = 0;
    end
  end

  task automatic clr_mon();
    mon_clr = 1'b1; @(negedge clk); @(negedge clk); mon_clr = 1'b0;
  endtask

  // host side of the bus
  task automatic wait_high();
    while (!scl_line) @(negedge clk);
  endtask
  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; repeat (H) @(negedge clk);
    sda_m = 1'b0; repeat (H) @(negedge clk);
  endtask
  task automatic bus_rstart();
    scl_m = 1'b0; repeat (H/2) @(negedge clk); sda_m = 1'b1; repeat (H/2) @(negedge clk);
    scl_m = 1'b1; wait_high(); repeat (H) @(negedge clk);
    sda_m = 1'b0; repeat (H) @(negedge clk);
  endtask
  task automatic bus_stop();
    scl_m = 1'b0; repeat (H/2) @(negedge clk); sda_m = 1'b0; repeat (H/2) @(negedge clk);
    scl_m = 1'b1; wait_high(); repeat (H) @(negedge clk);
    sda_m = 1'b1; repeat (H) @(negedge clk);
  endtask
  task automatic send_bit(input logic b);
    scl_m = 1'b0; repeat (H/2) @(negedge clk); sda_m = b; repeat (H/2) @(negedge clk);
    scl_m = 1'b1; wait_high(); repeat (H) @(negedge clk);
  endtask
  task automatic recv_bit(output logic b);
    scl_m = 1'b0; repeat (H/2) @(negedge clk); sda_m = 1'b1; repeat (H/2) @(negedge clk);
    scl_m = 1'b1; wait_high(); repeat (H/2) @(negedge clk);
    b = sda_line; repeat (H/2) @(negedge clk);
  endtask
  task automatic write_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = !b;
  endtask
  task automatic read_byte(input bit host_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(!host_ack);
  endtask

  logic [7:0] tx [0:15];
  // pmode: 0 no check byte, 1 correct, 2 corrupted
  task automatic write_txn(input logic [6:0] a, input int n, input int pmode, input string req);
    bit ack;
    logic [7:0] c;
    clr_mon();
    bus_start();
    write_byte({a, 1'b0}, ack);
    chk(ack, "R4 address ack", ack, 1);
    c = tb_crc(8'h00, {a, 1'b0});
    for (int i = 0; i < n; i++) begin
      write_byte(tx[i], ack);
      chk(ack, req, ack, 1);
      c = tb_crc(c, tx[i]);
    end
    if (pmode != 0) begin
      write_byte(pmode == 1 ? c : (c ^ 8'h01), ack);
      chk(ack, req, ack, 1);
    end
    bus_stop();
  endtask

  task automatic read_txn(input logic [7:0] cmd, input int n);
    bit ack;
    logic [7:0] v, c;
    logic [7:0] a = {own_addr, 1'b0};
    clr_mon();
    rsp_n = n;
    bus_start();
    write_byte(a, ack);        chk(ack, "R4 read addr-w ack", ack, 1);
    write_byte(cmd, ack);      chk(ack, "R5 command ack", ack, 1);
    bus_rstart();
    write_byte(a | 8'h01, ack); chk(ack, "R4 read addr-r ack after Sr", ack, 1);
    c = tb_crc(tb_crc(tb_crc(8'h00, a), cmd), a | 8'h01);
    for (int k = 0; k < n; k++) begin
      read_byte(1'b1, v);
      chk(v == rsp_mem[k], "R9 read data", v, rsp_mem[k]);
      c = tb_crc(c, rsp_mem[k]);
    end
    read_byte(1'b1, v);
    chk(v == c, "R10 read check byte", v, c);
    read_byte(1'b0, v);
    chk(v == 8'hFF, "R11 byte after check byte", v, 8'hFF);
    bus_stop();
    chk(ncommit == 1 && nabort == 0, "R10 command phase commit", ncommit, 1);
    chk(nwr == 1 && wcap[0] == cmd, "R10 command byte delivered", wcap[0], cmd);
    chk(max_run > 0 && max_run <= LIMIT, "R9 SCL stretched while waiting", max_run, rsp_delay);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !rd_req && !pec_err && !wr_valid, "R9 reset idle",
        {scl_oe, sda_oe, rd_req, pec_err}, 0);

    // R1 R2 R3: full strap sweep
    for (int h = 0; h < 16; h++) begin
      for (int l = 0; l < 16; l++) begin
        int ea;
        bit er;
        strap_hi = 4'(h); strap_lo = 4'(l);
        @(negedge clk);
        ea = (h < 8 && l < 8) ? h * 8 + l : 127;
        er = (ea < 13) || ea == 40 || ea == 44 || ea == 45 || ea == 55;
        chk(own_addr == 7'(ea), "R1 R2 strap address", own_addr, ea);
        chk(addr_reserved == er, "R3 fixed-address flag", addr_reserved, er);
      end
    end
    strap_hi = 4'd3; strap_lo = 4'd2;
    repeat (4) @(negedge clk);

    // R4: other address is not acknowledged
    clr_mon();
    bus_start();
    write_byte({7'd27, 1'b0}, ack);
    chk(!ack, "R4 foreign address nack", ack, 0);
    bus_stop();
    chk(nwr == 0 && ncommit == 0 && nabort == 0, "R4 no register traffic", nwr, 0);

    // R5: write without check byte
    wr_len = 8'd2; tx[0] = 8'h21; tx[1] = 8'hC4;
    write_txn(7'd26, 2, 0, "R5 data ack");
    chk(ncommit == 1 && nabort == 0, "R5 commit", ncommit, 1);
    chk(nwr == 2 && wcap[0] == 8'h21 && wcap[1] == 8'hC4, "R5 bytes in order", wcap[1], 8'hC4);

    // R6: correct check byte, not delivered
    tx[0] = 8'h3B; tx[1] = 8'h00;
    write_txn(7'd26, 2, 1, "R6 data ack");
    chk(ncommit == 1 && nabort == 0, "R6 commit with check byte", ncommit, 1);
    chk(nwr == 2, "R6 check byte withheld", nwr, 2);
    chk(!pec_err, "R6 no error", pec_err, 0);

    // R7: corrupted check byte, sticky flag
    tx[0] = 8'hE7; tx[1] = 8'h5F;
    write_txn(7'd26, 2, 2, "R7 data ack");
    chk(nabort == 1 && ncommit == 0, "R7 abort", nabort, 1);
    chk(pec_err, "R7 flag set", pec_err, 1);
    write_txn(7'd26, 2, 1, "R7 data ack");
    chk(pec_err && ncommit == 1, "R7 flag stays set", pec_err, 1);
    pec_err_clr = 1'b1; @(negedge clk); pec_err_clr = 1'b0; @(negedge clk);
    chk(!pec_err, "R7 flag cleared", pec_err, 0);

    // R8: bad lengths
    tx[2] = 8'h11; tx[3] = 8'h99;
    write_txn(7'd26, 4, 0, "R8 data ack");
    chk(nabort == 1 && ncommit == 0 && !pec_err, "R8 long write dropped", nabort, 1);
    write_txn(7'd26, 1, 0, "R8 data ack");
    chk(nabort == 1 && ncommit == 0 && !pec_err, "R8 short write dropped", nabort, 1);

    // R9 R10 R11: reads of several lengths
    wr_len = 8'd1;
    for (int p = 1; p <= 3; p++) begin
      for (int k = 0; k < 16; k++) rsp_mem[k] = 8'(8'h5A ^ (p * 37 + k * 11));
      rsp_delay = 20 + p * 40;
      read_txn(8'(8'h88 + p), p);
    end

    // R12: register side too slow
    rsp_delay = 1000;
    clr_mon();
    bus_start();
    write_byte({own_addr, 1'b0}, ack);
    write_byte(8'h8B, ack);
    bus_rstart();
    write_byte({own_addr, 1'b1}, ack);
    chk(ack, "R12 read address ack", ack, 1);
    read_byte(1'b0, v);
    chk(v == 8'hFF, "R12 abandoned read", v, 8'hFF);
    bus_stop();
    chk(max_run == LIMIT, "R12 stretch limit", max_run, LIMIT);
    chk(!rd_req && !scl_oe, "R12 released", rd_req, 0);
    rsp_delay = 60;

    // R2: invalid strap moves the engine to 127
    strap_hi = 4'd9; strap_lo = 4'd2;
    repeat (4) @(negedge clk);
    clr_mon();
    bus_start();
    write_byte({7'd26, 1'b0}, ack);
    chk(!ack, "R2 old address ignored", ack, 0);
    bus_stop();
    tx[0] = 8'h42;
    write_txn(7'd127, 1, 0, "R2 data ack");
    chk(ncommit == 1 && nwr == 1 && wcap[0] == 8'h42, "R2 fallback write", wcap[0], 8'h42);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule